// File: doc/BRIEF.md
# Ripple-Slice Integer ALU

This block is a purely combinational 32-bit arithmetic and logic unit built from a chain of identical one-bit slices. Each slice holds an AND gate, an OR gate, a full adder and a four-way result selector. The carry ripples from bit 0 upward. A small decoder turns a 4-bit operation code into the slice controls. These controls are the operand-B invert, the carry-in of bit 0, the result select, an arithmetic flag and a valid flag.

Signed compare reuses the subtract path. The most significant slice forms a "set" bit, which is its own sum bit corrected by the signed overflow of the subtraction. That bit is routed back into the "less" input of bit 0, and the less inputs of all other slices are tied low. The unit also reports a zero flag and a signed overflow flag. A datapath instantiates it between the register read ports and the write-back or address path.

Top module: `bs_alu`

## Requirements
- R1: Code 4'b0000 returns a_i AND b_i and code 4'b0001 returns a_i OR b_i, bit by bit.
- R2: Code 4'b0010 returns a_i + b_i modulo 2^32.
- R3: Code 4'b0110 returns a_i - b_i modulo 2^32, formed by inverting b_i in every slice and forcing carry-in of bit 0 to 1.
- R4: Code 4'b0111 returns 32'h1 when a_i is less than b_i as two's-complement signed numbers and 32'h0 otherwise. Bits 31:1 are always 0, and the answer stays correct when a_i - b_i overflows.
- R5: zero_o is 1 exactly when all 32 bits of result_o are 0, for every operation code.
- R6: ovf_o is 1 for codes 4'b0010 and 4'b0110 exactly when the signed result cannot be represented in 32 bits (carry into bit 31 differs from carry out of bit 31). It is 0 for every other code.
- R7: Every code other than 0000, 0001, 0010, 0110 and 0111 yields result_o = 0, so zero_o = 1 and ovf_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| op_i | input | 4 | Operation code |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | High when result_o is all zeros |
| ovf_o | output | 1 | Signed overflow of add or subtract |

## Verification
The compare path and the overflow detector act on the same subtraction. The tricky case is therefore a compare whose internal a - b overflows, such as the most negative value against the largest positive value and the reverse. In that case the raw top sum bit gives the wrong answer. These operand pairs are driven with code 0111 and also with code 0110. The bench then checks two things. The compare returns the true signed order in bit 0 with ovf_o held low. The subtract on the same operands raises ovf_o. Zero detection meets the compare as well, because a false compare must give an all-zero result and so raise zero_o.

// File: rtl/bs_alu_pkg.sv
package bs_alu_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'b0000,
    OP_OR  = 4'b0001,
    OP_ADD = 4'b0010,
    OP_SUB = 4'b0110,
    OP_SLT = 4'b0111
  } alu_op_e;

  typedef enum logic [1:0] {
    SEL_AND  = 2'd0,
    SEL_OR   = 2'd1,
    SEL_SUM  = 2'd2,
    SEL_LESS = 2'd3
  } sel_e;

  typedef struct packed {
    logic b_inv;  // also drives carry-in of bit 0
    sel_e sel;
    logic arith;  // overflow reported
    logic valid;
  } ctl_t;

  function automatic logic bit_pick(input sel_e sel, input logic a, input logic b,
                                    input logic sum, input logic less);
    case (sel)
      SEL_AND: bit_pick = a & b;
      SEL_OR:  bit_pick = a | b;
      SEL_SUM: bit_pick = sum;
      default: bit_pick = less;
    endcase
  endfunction
endpackage

// File: rtl/bs_alu_ctrl.sv
module bs_alu_ctrl
  import bs_alu_pkg::*;
(
  input  logic [3:0] op_i,
  output ctl_t       ctl_o
);
  always_comb begin
    ctl_o = '{b_inv: 1'b0, sel: SEL_AND, arith: 1'b0, valid: 1'b0};
    case (op_i)
      OP_AND: ctl_o = '{b_inv: 1'b0, sel: SEL_AND,  arith: 1'b0, valid: 1'b1};
      OP_OR:  ctl_o = '{b_inv: 1'b0, sel: SEL_OR,   arith: 1'b0, valid: 1'b1};
      OP_ADD: ctl_o = '{b_inv: 1'b0, sel: SEL_SUM,  arith: 1'b1, valid: 1'b1};
      OP_SUB: ctl_o = '{b_inv: 1'b1, sel: SEL_SUM,  arith: 1'b1, valid: 1'b1};
      OP_SLT: ctl_o = '{b_inv: 1'b1, sel: SEL_LESS, arith: 1'b0, valid: 1'b1};
      default: ;
    endcase
  end
endmodule

// File: rtl/bs_alu_bit.sv
module bs_alu_bit
  import bs_alu_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  input  logic b_inv_i,
  input  logic cin_i,
  input  logic less_i,
  input  sel_e sel_i,
  output logic res_o,
  output logic cout_o
);
  logic bx, sum;
  assign bx     = b_i ^ b_inv_i;
  assign sum    = a_i ^ bx ^ cin_i;
  assign cout_o = (a_i & bx) | (cin_i & (a_i ^ bx));
  assign res_o  = bit_pick(sel_i, a_i, b_i, sum, less_i);
endmodule

// File: rtl/bs_alu_msb.sv
module bs_alu_msb
  import bs_alu_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  input  logic b_inv_i,
  input  logic cin_i,
  input  sel_e sel_i,
  output logic res_o,
  output logic set_o,
  output logic ovf_o
);
  logic bx, sum, cout;
  assign bx    = b_i ^ b_inv_i;
  assign sum   = a_i ^ bx ^ cin_i;
  assign cout  = (a_i & bx) | (cin_i & (a_i ^ bx));
  assign ovf_o = cin_i ^ cout;
  // sign corrected by overflow keeps compare right at the extremes
  assign set_o = sum ^ ovf_o;
  assign res_o = bit_pick(sel_i, a_i, b_i, sum, 1'b0);
endmodule

// File: rtl/bs_alu.sv
module bs_alu
  import bs_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   op_i,
  output logic [W-1:0] result_o,
  output logic         zero_o,
  output logic         ovf_o
);
  localparam int MSB = W - 1;

  ctl_t         ctl;
  logic [MSB:0] carry;
  logic [MSB:0] raw;
  logic         set_w, ovf_raw;

  bs_alu_ctrl u_ctrl (.op_i(op_i), .ctl_o(ctl));

  assign carry[0] = ctl.b_inv;

  for (genvar i = 0; i < MSB; i++) begin : g_slice
    bs_alu_bit u_bit (
      .a_i    (a_i[i]),
      .b_i    (b_i[i]),
      .b_inv_i(ctl.b_inv),
      .cin_i  (carry[i]),
      .less_i ((i == 0) ? set_w : 1'b0),
      .sel_i  (ctl.sel),
      .res_o  (raw[i]),
      .cout_o (carry[i+1])
    );
  end

  bs_alu_msb u_msb (
    .a_i    (a_i[MSB]),
    .b_i    (b_i[MSB]),
    .b_inv_i(ctl.b_inv),
    .cin_i  (carry[MSB]),
    .sel_i  (ctl.sel),
    .res_o  (raw[MSB]),
    .set_o  (set_w),
    .ovf_o  (ovf_raw)
  );

  assign result_o = ctl.valid ? raw : '0;
  assign zero_o   = ~|result_o;
  assign ovf_o    = ctl.arith & ovf_raw;
endmodule

// File: rtl/bs_alu_chk.sv
module bs_alu_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [3:0]   op_i,
  input logic [W-1:0] result_o,
  input logic         zero_o,
  input logic         ovf_o
);
  logic known;
  assign known = !$isunknown({a_i, b_i, op_i});

  always_comb begin
    if (known) begin
      if (op_i == 4'b0010)
        AST_ADD_SUM: assert (result_o == a_i + b_i); // R2
      if (op_i == 4'b0110)
        AST_SUB_DIFF: assert (result_o == a_i - b_i); // R3
      if (op_i == 4'b0110)
        AST_SUB_ZERO: assert (zero_o == (a_i == b_i)); // R5
      if (op_i == 4'b0111)
        AST_SLT_BIT: assert (result_o == {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))}); // R4
      if (op_i != 4'b0010 && op_i != 4'b0110)
        AST_NO_OVERFLOW: assert (!ovf_o); // R6
      if (!(op_i inside {4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111}))
        AST_BAD_OP: assert (result_o == '0 && zero_o); // R7
    end
  end
endmodule

bind bs_alu bs_alu_chk #(.W(W)) u_chk (.*);

// File: tb/tb_bs_alu.sv
module tb_bs_alu;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] a, b, res;
  logic [3:0]  op;
  logic        zero, ovf;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  bs_alu dut (.a_i(a), .b_i(b), .op_i(op), .result_o(res), .zero_o(zero), .ovf_o(ovf));

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] r;
    logic        z;
    logic        v;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VT [NV] = '{
    '{4'b0000, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 1'b0, 1'b0, 8'd1},
    '{4'b0001, 32'hF0F0F0F0, 32'hFF00FF00, 32'hFFF0FFF0, 1'b0, 1'b0, 8'd1},
    '{4'b0000, 32'h7FFFFFFF, 32'h80000000, 32'h00000000, 1'b1, 1'b0, 8'd5},
    '{4'b0001, 32'h80000000, 32'h7FFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b0, 8'd6},
    '{4'b0010, 32'h00000001, 32'h00000001, 32'h00000002, 1'b0, 1'b0, 8'd2},
    '{4'b0010, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0, 1'b1, 8'd6},
    '{4'b0010, 32'h80000000, 32'h80000000, 32'h00000000, 1'b1, 1'b1, 8'd6},
    '{4'b0010, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b0, 8'd2},
    '{4'b0110, 32'h00000005, 32'h00000005, 32'h00000000, 1'b1, 1'b0, 8'd3},
    '{4'b0110, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b0, 1'b1, 8'd6},
    '{4'b0110, 32'h00000000, 32'h00000001, 32'hFFFFFFFF, 1'b0, 1'b0, 8'd3},
    '{4'b0110, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 1'b0, 1'b1, 8'd6},
    '{4'b0111, 32'h80000000, 32'h7FFFFFFF, 32'h00000001, 1'b0, 1'b0, 8'd4},
    '{4'b0111, 32'h7FFFFFFF, 32'h80000000, 32'h00000000, 1'b1, 1'b0, 8'd4},
    '{4'b0111, 32'hFFFFFFFF, 32'h00000001, 32'h00000001, 1'b0, 1'b0, 8'd4},
    '{4'b0111, 32'h00000001, 32'hFFFFFFFF, 32'h00000000, 1'b1, 1'b0, 8'd4},
    '{4'b0111, 32'h00000005, 32'h00000005, 32'h00000000, 1'b1, 1'b0, 8'd4},
    '{4'b1111, 32'h00000001, 32'h00000002, 32'h00000000, 1'b1, 1'b0, 8'd7},
    '{4'b0011, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b1, 1'b0, 8'd7},
    '{4'b1110, 32'h7FFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b0, 8'd7}
  };

  function automatic logic [33:0] ref_alu(input logic [3:0] o, input logic [31:0] x,
                                          input logic [31:0] y);
    logic [31:0] r;
    logic        v;
    r = 32'h0;
    v = 1'b0;
    case (o)
      4'b0000: r = x & y;
      4'b0001: r = x | y;
      4'b0010: begin r = x + y; v = (x[31] == y[31]) && (r[31] != x[31]); end
      4'b0110: begin r = x - y; v = (x[31] != y[31]) && (r[31] != x[31]); end
      4'b0111: r = {31'b0, $signed(x) < $signed(y)};
      default: r = 32'h0;
    endcase
    return {r, (r == 32'h0), v};
  endfunction

  task automatic apply(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                       input logic [31:0] er, input logic ez, input logic ev, input int rq);
    @(negedge clk);
    op = o; a = x; b = y;
    #1;
    n_run++;
    if (res !== er || zero !== ez || ovf !== ev) begin
      n_fail++;
      $display("FAIL R%0d op=%b a=%h b=%h: got res=%h z=%b v=%b exp res=%h z=%b v=%b",
               rq, o, x, y, res, zero, ovf, er, ez, ev);
    end
  endtask

  initial begin
    op = 4'b0; a = '0; b = '0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    // R5 reset-state: idle inputs give zero result
    apply(4'b0000, 32'h0, 32'h0, 32'h0, 1'b1, 1'b0, 5);
    for (int i = 0; i < NV; i++)
      apply(VT[i].op, VT[i].a, VT[i].b, VT[i].r, VT[i].z, VT[i].v, int'(VT[i].req));
    // R4 compare overflow corner with matching subtract (R6)
    apply(4'b0111, 32'h80000000, 32'h00000001, 32'h1, 1'b0, 1'b0, 4);
    apply(4'b0110, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b0, 1'b1, 6);
    // R1 R2 R3 R4 R7 random sweep against reference
    for (int i = 0; i < 3000; i++) begin
      logic [3:0]  o;
      logic [31:0] x, y;
      logic [33:0] e;
      case (i % 6)
        0: o = 4'b0000;
        1: o = 4'b0001;
        2: o = 4'b0010;
        3: o = 4'b0110;
        4: o = 4'b0111;
        default: o = 4'($urandom);
      endcase
      x = $urandom;
      y = (i % 11 == 0) ? x : $urandom;
      e = ref_alu(o, x, y);
      apply(o, x, y, e[33:2], e[1], e[0], (i % 6 == 5) ? 7 : (i % 6 < 2 ? 1 : i % 6));
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule